// File: doc/BRIEF.md
# CAN Receive Message Object Bank

This block stores received CAN frames for a CPU. A frame decoder upstream hands over each finished frame as an 11-bit identifier, a length code and up to eight data bytes, with a single-cycle valid strobe. The bank checks the identifier against a row of message objects. Each object has its own identifier and mask. The frame is then written into the first object that accepts it. Frames that no object accepts are dropped, and a pulse reports the drop.

Each object is set up in one of two ways. It can be a standalone mailbox that always holds the newest accepted frame. It can also be the head of a FIFO group, which takes over the objects that follow it and queues accepted frames in arrival order. Mailboxes and groups can sit side by side in one bank.

The CPU sets up objects through a one-cycle write port. It reads an object by putting its index on a read selector. A release strobe acknowledges a mailbox or pops the oldest entry of a group.

Top module: `can_obj_bank`

## Requirements
- R1: After reset every object is disabled. The read port shows `rd_avail`=0, `rd_lost`=0 and `rd_count`=0 for every index, and `rx_nomatch` and `fifo_irq` are 0.
- R2: A frame is accepted by an enabled object when `(rx_id ^ obj_id) & obj_mask` is zero. A mask bit of 1 makes the identifier bit significant, and a mask bit of 0 makes it a don't-care.
- R3: When several enabled objects accept a frame, only the lowest-numbered one stores it. The other objects keep their state.
- R4: A frame that no enabled object accepts changes no object. `rx_nomatch` is then high for exactly the one cycle after the `rx_valid` edge.
- R5: `cfg_size`=0 makes a mailbox. An accepted frame replaces the stored frame and sets new-data (`rd_avail`=1, `rd_count`=1). If new-data was already set, `rd_lost` also goes to 1.
- R6: A release of a mailbox clears both new-data and lost. A release that comes in the same cycle as a new frame for that mailbox counts as a read in time, so new-data ends at 1 and lost ends at 0.
- R7: `cfg_size`=k (1..5) makes object h the head of a FIFO group of 2^k entries, using objects h..h+2^k-1. The group must fit inside the bank. Reading the head gives the oldest entry, and `rd_count` gives the number of entries held. A release pops one entry.
- R8: When a group is full and no pop happens in the same cycle, a further accepted frame is discarded. The group's lost (overrun) flag is then set and no stored entry changes. A release of the group clears that flag.
- R9: `fifo_irq` is high for one cycle only when a group goes from empty to non-empty. Frames that arrive while the group already holds entries do not raise it.
- R10: The objects that a group covers, other than its head, ignore their own filter settings. A mailbox placed after the group still works on its own.
- R11: A stored frame becomes visible at the read port in the cycle after the `rx_valid` edge, and not before that edge.
- R12: A receive into a group and a release of that group in the same cycle both take effect. The count stays the same and the head moves on to the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a decoded frame |
| rx_id | input | 11 | Received identifier |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received data bytes |
| cfg_we | input | 1 | Writes one object's setup and clears its state |
| cfg_obj | input | OW | Index of the object being set up |
| cfg_en | input | 1 | Object enable |
| cfg_size | input | 3 | 0 = mailbox, k = FIFO head of 2^k entries |
| cfg_id | input | 11 | Acceptance identifier |
| cfg_mask | input | 11 | Acceptance mask (1 = bit must match) |
| rd_obj | input | OW | Index of the object being read |
| rd_release | input | 1 | Acknowledge mailbox or pop FIFO |
| rd_avail | output | 1 | New data or group not empty |
| rd_lost | output | 1 | Message-lost / overrun flag |
| rd_count | output | OW+1 | Entries held (mailbox: 0 or 1) |
| rd_id | output | 11 | Identifier of the shown frame |
| rd_dlc | output | 4 | Length code of the shown frame |
| rd_data | output | 64 | Data of the shown frame |
| rx_nomatch | output | 1 | Pulse: the last frame was dropped |
| fifo_irq | output | 1 | Pulse: a group went from empty to non-empty |

## Verification
Two events can land on one object in the same clock edge: an incoming frame and a CPU release. The bench drives `rx_valid` and `rd_release` in the same cycle, once aimed at a mailbox and once at a FIFO group that holds one entry. For the mailbox, the result must show new-data set, lost clear and the new payload. For the group, the count must stay at one, the head must show the newer frame, and no interrupt may fire. Overrun against a full group is tested separately, so that a pop in the same cycle cannot hide it.

// File: rtl/can_obj_pkg.sv
package can_obj_pkg;
    localparam int ID_W   = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int SZ_W   = 3;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } can_frame_t;

    typedef struct packed {
        logic              en;
        logic [SZ_W-1:0]   sz;
        logic [ID_W-1:0]   id;
        logic [ID_W-1:0]   mask;
    } obj_cfg_t;

    function automatic logic id_accept(input logic [ID_W-1:0] rx,
                                       input logic [ID_W-1:0] id,
                                       input logic [ID_W-1:0] mask);
        return ((rx ^ id) & mask) == '0;
    endfunction
endpackage

// File: rtl/can_obj_cfg.sv
module can_obj_cfg
    import can_obj_pkg::*;
#(
    parameter int N_OBJ = 16,
    parameter int OW    = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic [OW-1:0] obj,
    input  obj_cfg_t wdata,
    output obj_cfg_t cfg [N_OBJ]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_OBJ; i++) cfg[i] <= '0;
        end else if (we) begin
            cfg[obj] <= wdata;
        end
    end
endmodule

// File: rtl/can_obj_filter.sv
module can_obj_filter
    import can_obj_pkg::*;
#(
    parameter int N_OBJ = 16,
    parameter int OW    = 4
) (
    input  obj_cfg_t        cfg [N_OBJ],
    input  logic [ID_W-1:0] rx_id,
    output logic            hit,
    output logic [OW-1:0]   win
);
    logic [N_OBJ-1:0] covered;
    logic [N_OBJ-1:0] accept;

    always_comb begin
        for (int j = 0; j < N_OBJ; j++) begin
            covered[j] = 1'b0;
            for (int h = 0; h < N_OBJ; h++) begin
                if (h < j && cfg[h].en && cfg[h].sz != '0 &&
                    j < h + (1 << cfg[h].sz))
                    covered[j] = 1'b1;
            end
            accept[j] = cfg[j].en && !covered[j] &&
                        id_accept(rx_id, cfg[j].id, cfg[j].mask);
        end
    end

    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int j = N_OBJ - 1; j >= 0; j--) begin
            if (accept[j]) begin
                hit = 1'b1;
                win = OW'(j);
            end
        end
    end
endmodule

// File: rtl/can_obj_store.sv
module can_obj_store
    import can_obj_pkg::*;
#(
    parameter int N_OBJ = 16,
    parameter int OW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  obj_cfg_t      cfg [N_OBJ],
    input  logic          wr_en,
    input  logic [OW-1:0] win,
    input  can_frame_t    frame,
    input  logic          rel,
    input  logic [OW-1:0] rd_obj,
    input  logic          clr,
    input  logic [OW-1:0] clr_obj,
    output can_frame_t    rd_frame,
    output logic          rd_avail,
    output logic          rd_lost,
    output logic [OW:0]   rd_count,
    output logic          irq
);
    can_frame_t    mem   [N_OBJ];
    logic          newf  [N_OBJ];
    logic          lost  [N_OBJ];
    logic [OW-1:0] wp    [N_OBJ];
    logic [OW-1:0] rp    [N_OBJ];
    logic [OW:0]   cnt   [N_OBJ];

    logic          w_fifo, w_full, w_rel, w_pop, push;
    logic [OW:0]   w_depth;
    logic [OW-1:0] w_wrap, r_wrap, w_slot, r_slot;
    logic          r_fifo;
    logic [N_OBJ-1:0] push_v, pop_v;

    always_comb begin
        w_fifo  = cfg[win].sz != '0;
        w_depth = (OW+1)'(1) << cfg[win].sz;
        w_wrap  = OW'(w_depth - 1'b1);
        w_full  = cnt[win] == w_depth;
        w_rel   = rel && rd_obj == win;
        w_pop   = w_rel && w_fifo && cnt[win] != '0;
        push    = wr_en && w_fifo && (!w_full || w_pop);
        w_slot  = w_fifo ? win + wp[win] : win;
        r_fifo  = cfg[rd_obj].sz != '0;
        r_wrap  = OW'(((OW+1)'(1) << cfg[rd_obj].sz) - 1'b1);
        r_slot  = r_fifo ? rd_obj + rp[rd_obj] : rd_obj;
        for (int i = 0; i < N_OBJ; i++) begin
            push_v[i] = push && win == OW'(i);
            pop_v[i]  = rel && rd_obj == OW'(i) && cfg[i].sz != '0 && cnt[i] != '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && (!w_fifo || push)) mem[w_slot] <= frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            for (int i = 0; i < N_OBJ; i++) begin
                newf[i] <= 1'b0; lost[i] <= 1'b0;
                wp[i] <= '0; rp[i] <= '0; cnt[i] <= '0;
            end
        end else begin
            irq <= 1'b0;
            if (rel) begin
                lost[rd_obj] <= 1'b0;
                if (!r_fifo) newf[rd_obj] <= 1'b0;
                else if (cnt[rd_obj] != '0) rp[rd_obj] <= (rp[rd_obj] + 1'b1) & r_wrap;
            end
            if (wr_en) begin
                if (!w_fifo) begin
                    newf[win] <= 1'b1;
                    lost[win] <= newf[win] && !w_rel;
                end else if (push) begin
                    wp[win] <= (wp[win] + 1'b1) & w_wrap;
                    if (cnt[win] == '0) irq <= 1'b1;
                end else begin
                    lost[win] <= 1'b1;
                end
            end
            for (int i = 0; i < N_OBJ; i++) begin
                if (push_v[i] && !pop_v[i]) cnt[i] <= cnt[i] + 1'b1;
                else if (pop_v[i] && !push_v[i]) cnt[i] <= cnt[i] - 1'b1;
            end
            if (clr) begin
                newf[clr_obj] <= 1'b0; lost[clr_obj] <= 1'b0;
                wp[clr_obj] <= '0; rp[clr_obj] <= '0; cnt[clr_obj] <= '0;
            end
        end
    end

    always_comb begin
        rd_frame = mem[r_slot];
        rd_avail = r_fifo ? cnt[rd_obj] != '0 : newf[rd_obj];
        rd_lost  = lost[rd_obj];
        rd_count = r_fifo ? cnt[rd_obj] : {{OW{1'b0}}, newf[rd_obj]};
    end

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(wr_en));

    for (genvar g = 0; g < N_OBJ; g++) begin : g_chk
        a_r5_mailbox_new: assert property (@(posedge clk) disable iff (rst)
            (wr_en && win == OW'(g) && cfg[g].sz == '0 && !(clr && clr_obj == OW'(g)))
            |=> newf[g]);
        a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
            (cfg[g].sz != '0 && int'(cfg[g].sz) <= OW)
            |-> cnt[g] <= ((OW+1)'(1) << cfg[g].sz));
        a_r8_lost_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(lost[g]) |-> $past(wr_en && win == OW'(g)));
    end
endmodule

// File: rtl/can_obj_bank.sv
module can_obj_bank
    import can_obj_pkg::*;
#(
    parameter int N_OBJ = 16,
    localparam int OW   = $clog2(N_OBJ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [10:0]   rx_id,
    input  logic [3:0]    rx_dlc,
    input  logic [63:0]   rx_data,
    input  logic          cfg_we,
    input  logic [OW-1:0] cfg_obj,
    input  logic          cfg_en,
    input  logic [2:0]    cfg_size,
    input  logic [10:0]   cfg_id,
    input  logic [10:0]   cfg_mask,
    input  logic [OW-1:0] rd_obj,
    input  logic          rd_release,
    output logic          rd_avail,
    output logic          rd_lost,
    output logic [OW:0]   rd_count,
    output logic [10:0]   rd_id,
    output logic [3:0]    rd_dlc,
    output logic [63:0]   rd_data,
    output logic          rx_nomatch,
    output logic          fifo_irq
);
    obj_cfg_t      cfg [N_OBJ];
    obj_cfg_t      cfg_wdata;
    can_frame_t    rx_frame, rd_frame;
    logic          hit;
    logic [OW-1:0] win;

    assign cfg_wdata = '{en: cfg_en, sz: cfg_size, id: cfg_id, mask: cfg_mask};
    assign rx_frame  = '{id: rx_id, dlc: rx_dlc, data: rx_data};

    can_obj_cfg #(.N_OBJ(N_OBJ), .OW(OW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .obj(cfg_obj),
        .wdata(cfg_wdata), .cfg(cfg));

    can_obj_filter #(.N_OBJ(N_OBJ), .OW(OW)) u_filter (
        .cfg(cfg), .rx_id(rx_id), .hit(hit), .win(win));

    can_obj_store #(.N_OBJ(N_OBJ), .OW(OW)) u_store (
        .clk(clk), .rst(rst), .cfg(cfg),
        .wr_en(rx_valid && hit), .win(win), .frame(rx_frame),
        .rel(rd_release), .rd_obj(rd_obj),
        .clr(cfg_we), .clr_obj(cfg_obj),
        .rd_frame(rd_frame), .rd_avail(rd_avail), .rd_lost(rd_lost),
        .rd_count(rd_count), .irq(fifo_irq));

    assign rd_id   = rd_frame.id;
    assign rd_dlc  = rd_frame.dlc;
    assign rd_data = rd_frame.data;

    always_ff @(posedge clk) begin
        if (rst) rx_nomatch <= 1'b0;
        else     rx_nomatch <= rx_valid && !hit;
    end

    a_r4_nomatch_cause: assert property (@(posedge clk) disable iff (rst)
        rx_nomatch |-> $past(rx_valid));
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rx_nomatch && fifo_irq));
endmodule

// File: tb/can_obj_bank_bench.sv
module can_obj_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [10:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_obj = '0;
    logic        cfg_en = 1'b0;
    logic [2:0]  cfg_size = '0;
    logic [10:0] cfg_id = '0;
    logic [10:0] cfg_mask = '0;
    logic [3:0]  rd_obj = '0;
    logic        rd_release = 1'b0;
    logic        rd_avail, rd_lost, rx_nomatch, fifo_irq;
    logic [4:0]  rd_count;
    logic [10:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    can_obj_bank #(.N_OBJ(16)) u_can_obj_bank (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_dlc(rx_dlc), .rx_data(rx_data), .cfg_we(cfg_we),
        .cfg_obj(cfg_obj), .cfg_en(cfg_en), .cfg_size(cfg_size),
        .cfg_id(cfg_id), .cfg_mask(cfg_mask), .rd_obj(rd_obj),
        .rd_release(rd_release), .rd_avail(rd_avail), .rd_lost(rd_lost),
        .rd_count(rd_count), .rd_id(rd_id), .rd_dlc(rd_dlc),
        .rd_data(rd_data), .rx_nomatch(rx_nomatch), .fifo_irq(fifo_irq));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(input int o, input bit en, input int sz, input logic [10:0] id,
                         input logic [10:0] mask);
        @(negedge clk);
        cfg_we = 1'b1; cfg_obj = o[3:0]; cfg_en = en; cfg_size = sz[2:0];
        cfg_id = id; cfg_mask = mask;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [10:0] id, input logic [63:0] d, input bit rel,
                        input int ro);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = id; rx_dlc = 4'd8; rx_data = d;
        rd_release = rel; if (rel) rd_obj = ro[3:0];
        @(negedge clk);
        rx_valid = 1'b0; rd_release = 1'b0;
    endtask

    task automatic release_obj(input int o);
        @(negedge clk);
        rd_obj = o[3:0]; rd_release = 1'b1;
        @(negedge clk);
        rd_release = 1'b0;
    endtask

    task automatic look(input int o);
        rd_obj = o[3:0];
        #1;
    endtask

    task automatic t_reset;
        for (int o = 0; o < 16; o++) begin
            look(o);
            chk("R1 avail after reset", {63'd0, rd_avail}, 64'd0);
            chk("R1 lost after reset", {63'd0, rd_lost}, 64'd0);
            chk("R1 count after reset", {59'd0, rd_count}, 64'd0);
        end
        chk("R1 nomatch after reset", {63'd0, rx_nomatch}, 64'd0);
        chk("R1 irq after reset", {63'd0, fifo_irq}, 64'd0);
    endtask

    task automatic t_config;
        setup(0, 1, 0, 11'h100, 11'h7FF);
        setup(1, 1, 0, 11'h200, 11'h700);
        setup(2, 1, 0, 11'h100, 11'h7FF);
        setup(4, 1, 2, 11'h300, 11'h7F0);
        setup(5, 1, 0, 11'h3FF, 11'h000);
        setup(8, 1, 0, 11'h055, 11'h7FF);
    endtask

    task automatic t_nomatch;
        send(11'h7AA, 64'h1, 0, 0);
        chk("R4 nomatch pulse", {63'd0, rx_nomatch}, 64'd1);
        look(5);
        chk("R10 covered member ignored", {63'd0, rd_avail}, 64'd0);
        look(4);
        chk("R4 no object changed", {59'd0, rd_count}, 64'd0);
        @(negedge clk);
        chk("R4 pulse lasts one cycle", {63'd0, rx_nomatch}, 64'd0);
    endtask

    task automatic t_mailbox;
        send(11'h100, 64'hAAAA_0001, 0, 0);
        chk("R4 no pulse on hit", {63'd0, rx_nomatch}, 64'd0);
        look(0);
        chk("R5 new data", {63'd0, rd_avail}, 64'd1);
        chk("R5 data", rd_data, 64'hAAAA_0001);
        chk("R5 no loss yet", {63'd0, rd_lost}, 64'd0);
        look(2);
        chk("R3 higher index untouched", {63'd0, rd_avail}, 64'd0);
        send(11'h100, 64'hBBBB_0002, 0, 0);
        look(0);
        chk("R5 overwrite keeps newest", rd_data, 64'hBBBB_0002);
        chk("R5 lost set", {63'd0, rd_lost}, 64'd1);
        release_obj(0);
        look(0);
        chk("R6 release clears new", {63'd0, rd_avail}, 64'd0);
        chk("R6 release clears lost", {63'd0, rd_lost}, 64'd0);
    endtask

    task automatic t_mask;
        send(11'h2F3, 64'hC0C0, 0, 0);
        look(1);
        chk("R2 masked group accepted", {53'd0, rd_id}, 64'h2F3);
        chk("R2 no nomatch", {63'd0, rx_nomatch}, 64'd0);
        send(11'h3F3, 64'hC1C1, 0, 0);
        chk("R2 significant bit differs", {63'd0, rx_nomatch}, 64'd1);
        look(1);
        chk("R2 object kept old frame", rd_data, 64'hC0C0);
    endtask

    task automatic t_fifo;
        for (int k = 1; k <= 4; k++) begin
            send(11'h300 + 11'(k), 64'(k), 0, 0);
            chk("R9 irq only on first entry", {63'd0, fifo_irq}, (k == 1) ? 64'd1 : 64'd0);
        end
        look(4);
        chk("R7 count full", {59'd0, rd_count}, 64'd4);
        chk("R7 oldest first", {53'd0, rd_id}, 64'h301);
        send(11'h305, 64'h5, 0, 0);
        look(4);
        chk("R8 overrun flag", {63'd0, rd_lost}, 64'd1);
        chk("R8 count unchanged", {59'd0, rd_count}, 64'd4);
        chk("R8 head unchanged", {53'd0, rd_id}, 64'h301);
        for (int k = 1; k <= 4; k++) begin
            look(4);
            chk("R7 arrival order", rd_data, 64'(k));
            release_obj(4);
            look(4);
            chk("R8 release clears overrun", {63'd0, rd_lost}, 64'd0);
            chk("R7 count after pop", {59'd0, rd_count}, 64'(4 - k));
        end
        chk("R7 empty", {63'd0, rd_avail}, 64'd0);
    endtask

    task automatic t_same_cycle;
        send(11'h30A, 64'hA, 0, 0);
        chk("R9 irq after empty", {63'd0, fifo_irq}, 64'd1);
        send(11'h30B, 64'hB, 1, 4);
        chk("R12 no irq when not empty", {63'd0, fifo_irq}, 64'd0);
        look(4);
        chk("R12 count kept", {59'd0, rd_count}, 64'd1);
        chk("R12 head advanced", {53'd0, rd_id}, 64'h30B);
        chk("R12 no overrun", {63'd0, rd_lost}, 64'd0);
        look(8);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = 11'h055; rx_data = 64'hD1;
        #1;
        chk("R11 not visible before edge", {63'd0, rd_avail}, 64'd0);
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk("R11 visible after edge", {63'd0, rd_avail}, 64'd1);
        chk("R10 mailbox after group", rd_data, 64'hD1);
        send(11'h055, 64'hD2, 1, 8);
        look(8);
        chk("R6 same-cycle new set", {63'd0, rd_avail}, 64'd1);
        chk("R6 same-cycle no loss", {63'd0, rd_lost}, 64'd0);
        chk("R6 same-cycle data", rd_data, 64'hD2);
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_config;
        t_nomatch;
        t_mailbox;
        t_mask;
        t_fifo;
        t_same_cycle;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule